// File: doc/BRIEF.md
# Bus turnaround idle-cycle inserter

This block sits between the external bus arbiter and the chip-select bus sequencer. It holds back the start of an external access for a programmable number of idle bus cycles when the bus needs to turn around after a read. The eight chip-select spaces form four pairs: space n and space n+4 share one pair, and the pair index is the low two bits of the space number. Each pair has a 2-bit idle-count field in a 16-bit configuration register.

A requester raises `req_valid` with a space number and a direction, and holds them until the block pulses `start`. The block keeps the pair and direction of the last access it started. A turnaround is needed when the last access was a read and the new one is either a write to the same pair or any access to another pair. In that case `start` is withheld for the count programmed for the pair of the previous read. Otherwise `start` is given in the same cycle as the request.

Top module: `bus_turnaround_idle`

## Requirements
- R1: The configuration register resets to 0xFF00. Bits 15:8 are readable and writable. Bits 7:0 always read as zero and ignore writes.
- R2: The idle field of pair p (spaces p and p+4) occupies bits 9+2p down to 8+2p: pair 0 uses bits 9:8, pair 1 uses 11:10, pair 2 uses 13:12 and pair 3 uses 15:14.
- R3: A field value of 0, 1, 2 or 3 inserts exactly that many idle cycles.
- R4: After a read, a write to either space of the same pair waits for the idle count of that pair.
- R5: After a read, an access of either direction to a space of another pair waits for the idle count of the pair that was read.
- R6: A read after a read to the same pair starts with no idle cycle.
- R7: Any access that follows a write starts with no idle cycle.
- R8: The first access after reset starts with no idle cycle.
- R9: Suppose a request is first presented in cycle T and needs N idle cycles. Then `start` is low in cycles T to T+N-1 and high in cycle T+N. When N is 0, `start` is high in cycle T.
- R10: A configuration write during a countdown does not change that countdown. The new value is used from the next access decision onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration register read value |
| req_valid | input | 1 | Access request, held until `start` |
| req_space | input | 3 | Target chip-select space of the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| start | output | 1 | Start strobe to the bus sequencer; also accepts the request |

## Verification
The hardest situation to reach from the ports is a configuration write that lands in the middle of a countdown. The bench sets a three-cycle gap and starts a read. It then presents a write to the same pair, and while the countdown runs it rewrites the field to zero. It checks that the current gap still lasts three cycles and that a later turnaround uses the new value. Beyond that, the bench sweeps every ordered pair of (space, direction) accesses under four rotated field settings. It compares each measured latency with a count it computes arithmetically.

// File: rtl/bus_turnaround_idle.sv
module bus_turnaround_idle #(
  parameter int SPACE_W = 3,
  parameter int CNT_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [15:0]        cfg_wdata,
  output logic [15:0]        cfg_rdata,
  input  logic               req_valid,
  input  logic [SPACE_W-1:0] req_space,
  input  logic               req_write,
  output logic               start
);

  localparam int PAIR_W = SPACE_W - 1;
  localparam int NPAIR  = 1 << PAIR_W;
  localparam int FLD_W  = NPAIR * CNT_W;

  logic [FLD_W-1:0]  idle_f;
  logic              last_vld, last_wr;
  logic [PAIR_W-1:0] last_pair;
  logic              busy;
  logic [CNT_W-1:0]  cnt;

  wire [PAIR_W-1:0] req_pair = req_space[PAIR_W-1:0];
  wire [CNT_W-1:0]  gap      = idle_f[last_pair*CNT_W +: CNT_W];
  wire              turn     = last_vld && !last_wr && (req_write || req_pair != last_pair);
  wire              need     = turn && gap != '0;

  assign cfg_rdata = {idle_f, {(16-FLD_W){1'b0}}};
  assign start     = req_valid && (busy ? (cnt == '0) : !need);

  always_ff @(posedge clk) begin
    if (!rst_n) idle_f <= '1;
    else if (cfg_we) idle_f <= cfg_wdata[15 -: FLD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (req_valid && need) begin
        busy <= 1'b1;
        cnt  <= gap - 1'b1;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (req_valid) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_vld  <= 1'b0;
      last_wr   <= 1'b0;
      last_pair <= '0;
    end else if (start) begin
      last_vld  <= 1'b1;
      last_wr   <= req_write;
      last_pair <= req_pair;
    end
  end

  // R1
  cfg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) && $past(rst_n) |-> cfg_rdata[15 -: FLD_W] == $past(cfg_wdata[15 -: FLD_W]));

  // R9
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 |-> !start);

  // R9
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 |=> busy && cnt == $past(cnt) - 1'b1);

  // R7
  after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && req_write ##1 req_valid |-> start);

  // R6
  read_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !req_write ##1 (req_valid && !req_write && req_pair == $past(req_pair)) |-> start);

endmodule

// File: tb/bus_turnaround_idle_tb.sv
`timescale 1ns/1ps
module bus_turnaround_idle_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [2:0]  req_space = '0;
  logic        req_write = 1'b0;
  logic        start;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bus_turnaround_idle u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_space(req_space),
    .req_write(req_write), .start(start)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [2:0] sp, input bit wr, input int wr_at,
                        input logic [15:0] wv, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_space = sp; req_write = wr; lat = 0;
    while (1) begin
      #0.5;
      if (start) break;
      if (lat == wr_at) begin cfg_we = 1'b1; cfg_wdata = wv; end
      @(negedge clk);
      cfg_we = 1'b0;
      lat++;
      if (lat > 20) break;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [15:0] cfg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check(cfg_rdata == 16'hFF00, "R1 reset value", cfg_rdata, 16'hFF00);

    access(3'd6, 1'b1, -1, '0, lat);
    check(lat == 0, "R8 first access after reset", lat, 0);

    cfg_write(16'h12AB);
    #0.5;
    check(cfg_rdata == 16'h1200, "R1 low byte reads zero", cfg_rdata, 16'h1200);
    cfg_write(16'hFFFF);
    #0.5;
    check(cfg_rdata == 16'hFF00, "R1 readback", cfg_rdata, 16'hFF00);

    for (int rot = 0; rot < 4; rot++) begin
      cfg = '0;
      for (int p = 0; p < 4; p++) cfg[8 + 2*p +: 2] = 2'((p + rot) % 4);
      cfg_write(cfg);
      #0.5;
      check(cfg_rdata == cfg, "R1 field write", cfg_rdata, cfg);
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int  exp;
          bit  aw, bw, same;
          string tag;
          aw = a[3]; bw = b[3];
          same = (a[1:0] == b[1:0]);
          exp = 0;
          if (!aw && (bw || !same)) exp = (a[1:0] + rot) % 4;
          if (aw)        tag = "R7 after write (R9)";
          else if (!same) tag = "R5 other pair (R2,R3,R9)";
          else if (bw)   tag = "R4 read then write (R2,R3,R9)";
          else           tag = "R6 read then read (R9)";
          access(3'(a[2:0]), aw, -1, '0, lat);
          access(3'(b[2:0]), bw, -1, '0, lat);
          check(lat == exp, tag, lat, exp);
        end
      end
    end

    cfg_write(16'h0300);
    access(3'd4, 1'b0, -1, '0, lat);
    access(3'd0, 1'b1, 1, 16'h0000, lat);
    check(lat == 3, "R10 countdown unaffected by write", lat, 3);
    #0.5;
    check(cfg_rdata == 16'h0000, "R10 register took new value", cfg_rdata, 0);
    access(3'd0, 1'b0, -1, '0, lat);
    access(3'd4, 1'b1, -1, '0, lat);
    check(lat == 0, "R10 new value used next", lat, 0);

    cfg_write(16'h4000);
    access(3'd7, 1'b0, -1, '0, lat);
    access(3'd1, 1'b0, -1, '0, lat);
    check(lat == 1, "R5 pair 3 one idle (R2,R3)", lat, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule